// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog peripheral on a small register bus. Software starts it by writing a start key. It then counts down from a programmable reload value, one step per prescaler tick. To keep the system alive, software must write a feed key before the count runs out. If the count runs out, the block drives a reset pulse of fixed length. It then returns to its power-on stopped state. Once the watchdog is running, software cannot stop it.

The prescaler and reload registers are write-protected. A write to either is accepted only after an unlock key has been written. Any other key write locks them again. An accepted write goes into a shadow copy and raises a pending flag. The new value moves into the counting logic a fixed number of clocks later, and the flag then drops.

The control sequencer has three states. `ST_IDLE` is stopped. `ST_RUN` is counting. `ST_BITE` drives the reset pulse. The transitions are:
- `ST_IDLE` to `ST_RUN` on the start key.
- `ST_RUN` to `ST_BITE` on a tick that finds the counter at zero with no feed in the same cycle.
- `ST_BITE` to `ST_IDLE` when the pulse counter expires.

No other transition exists.

Top module: `wdg_top`

## Requirements
- R1: After reset the block is stopped and `wdg_rst` is low. The prescaler register (address 1) reads 0. The reload register (address 2) reads all ones. The status register (address 3) reads 0. Reads of address 0 return 0.
- R2: Writing 0xCCCC to the key register (address 0) while stopped starts the watchdog. The counter loads the active reload value R. `wdg_rst` rises exactly (R+1)*D clock edges after the start write edge, where D is the tick divider.
- R3: The 3-bit prescaler code c selects the divider D = 4 << c for c = 0 to 6, giving ÷4 to ÷256. Code 7 also selects ÷256.
- R4: Writing 0xAAAA to the key register while running reloads the counter with the active reload value. It also clears the prescaler's internal count. `wdg_rst` then rises (R+1)*D edges after the feed edge.
- R5: Writing 0x5555 to the key register unlocks the prescaler and reload registers. Any other key write locks them again. Writes to them while locked leave their read-back value unchanged.
- R6: An accepted prescaler write sets status bit 0. An accepted reload write sets status bit 1. Each bit clears SYNC_CYCLES clock edges after its write edge. At that edge the written value becomes the one the counter uses.
- R7: While running, a key write other than 0xAAAA, including 0xCCCC and 0x5555, neither stops the watchdog nor changes when `wdg_rst` rises.
- R8: `wdg_rst` stays high for exactly PULSE_CYCLES clocks. Afterwards the block is stopped, locked, and holds its reset register values.
- R9: While stopped, key writes other than 0xCCCC (including 0xAAAA) do not start the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 key, 1 prescaler, 2 reload, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| wdg_rst | output | 1 | System reset pulse request |

## Verification
The bench builds the block with a 6-bit reload, SYNC_CYCLES of 3 and PULSE_CYCLES of 4. With a 6-bit reload, the power-on reload value of 63 can be read back, and every timeout stays short. This makes it possible to sweep all eight prescaler codes against several reload values. Each timeout, measured in clocks, is compared with (R+1)*D computed in the bench. The short settle and pulse lengths let the bench check the pending flags and the pulse width cycle by cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_BITE = 2'd2
    } wdg_state_t;

    localparam logic [15:0] KEY_UNLOCK = 16'h5555;
    localparam logic [15:0] KEY_FEED   = 16'hAAAA;
    localparam logic [15:0] KEY_START  = 16'hCCCC;

    localparam logic [1:0] A_KEY  = 2'd0;
    localparam logic [1:0] A_PRE  = 2'd1;
    localparam logic [1:0] A_RLD  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    localparam int PRE_W  = 3;
    localparam int PDIV_W = 8;
endpackage

// File: rtl/wdg_pend.sv
module wdg_pend #(
    parameter int W           = 3,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter int SYNC_CYCLES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] din,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active,
    output logic         busy
);
    localparam int TW = $clog2(SYNC_CYCLES + 1);

    logic [TW-1:0] tmr;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shadow <= RST_VAL;
            active <= RST_VAL;
            busy   <= 1'b0;
            tmr    <= '0;
        end else if (wr) begin
            shadow <= din;
            busy   <= 1'b1;
            tmr    <= TW'(SYNC_CYCLES);
        end else if (busy) begin
            if (tmr == TW'(1)) begin
                active <= shadow;
                busy   <= 1'b0;
                tmr    <= '0;
            end else begin
                tmr <= tmr - 1'b1;
            end
        end
    end

    // R6
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> (busy && shadow == $past(din)));

    // R6
    pend_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(clr)) |-> (active == shadow));
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [PRE_W-1:0] code,
    output logic             tick
);
    logic [PRE_W-1:0]  sel;
    logic [PDIV_W:0]   div;
    logic [PDIV_W-1:0] last;
    logic [PDIV_W-1:0] cnt;

    always_comb begin
        sel  = (code > PRE_W'(6)) ? PRE_W'(6) : code;
        div  = (PDIV_W + 1)'(4) << sel;
        last = PDIV_W'(div - 1'b1);
        tick = en && (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr || !en) |=> (!tick || last == '0));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> (cnt == '0));
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int RLD_W        = 12,
    parameter int SYNC_CYCLES  = 3,
    parameter int PULSE_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        wdg_rst
);
    localparam int BC_W = $clog2(PULSE_CYCLES + 1);

    wdg_state_t       state, state_nx;
    logic             unlocked;
    logic             key_wr, start_ev, feed_ev, soft_clr, tick;
    logic             pre_wr, rld_wr, pvu, rvu;
    logic [PRE_W-1:0] pre_sh, pre_act;
    logic [RLD_W-1:0] rld_sh, rld_act, cnt;
    logic [BC_W-1:0]  bite_cnt;

    assign key_wr   = bus_we && (bus_addr == A_KEY);
    assign start_ev = key_wr && (bus_wdata == KEY_START) && (state == ST_IDLE);
    assign feed_ev  = key_wr && (bus_wdata == KEY_FEED) && (state == ST_RUN);
    assign pre_wr   = bus_we && (bus_addr == A_PRE) && unlocked;
    assign rld_wr   = bus_we && (bus_addr == A_RLD) && unlocked;
    assign soft_clr = (state == ST_BITE) && (bite_cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            unlocked <= 1'b0;
        end else if (key_wr) begin
            unlocked <= (bus_wdata == KEY_UNLOCK);
        end
    end

    wdg_pend #(.W(PRE_W), .RST_VAL('0), .SYNC_CYCLES(SYNC_CYCLES)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .wr(pre_wr),
        .din(bus_wdata[PRE_W-1:0]), .shadow(pre_sh), .active(pre_act), .busy(pvu)
    );

    wdg_pend #(.W(RLD_W), .RST_VAL({RLD_W{1'b1}}), .SYNC_CYCLES(SYNC_CYCLES)) u_rld (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .wr(rld_wr),
        .din(bus_wdata[RLD_W-1:0]), .shadow(rld_sh), .active(rld_act), .busy(rvu)
    );

    wdg_prescaler u_div (
        .clk(clk), .rst_n(rst_n), .clr(feed_ev), .en(state == ST_RUN),
        .code(pre_act), .tick(tick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start_ev) state_nx = ST_RUN;
            ST_RUN:  if (tick && cnt == '0 && !feed_ev) state_nx = ST_BITE;
            ST_BITE: if (bite_cnt == '0) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdg_rst  <= 1'b0;
            cnt      <= '0;
            bite_cnt <= '0;
        end else begin
            wdg_rst <= (state_nx == ST_BITE);
            if (start_ev || feed_ev) begin
                cnt <= rld_act;
            end else if (state == ST_RUN && tick && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (state != ST_BITE && state_nx == ST_BITE) begin
                bite_cnt <= BC_W'(PULSE_CYCLES - 1);
            end else if (state == ST_BITE && bite_cnt != '0) begin
                bite_cnt <= bite_cnt - 1'b1;
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_PRE:   bus_rdata = 16'(pre_sh);
            A_RLD:   bus_rdata = 16'(rld_sh);
            A_STAT:  bus_rdata = {14'd0, rvu, pvu};
            default: bus_rdata = 16'd0;
        endcase
    end

    // R2
    start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_RUN && cnt == $past(rld_act)));

    // R2
    bite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tick && cnt == '0 && !feed_ev) |=> wdg_rst);

    // R7
    no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (state != ST_IDLE));

    // R8
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (state == ST_IDLE && !wdg_rst && !unlocked));

    // R5
    locked_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_PRE && !unlocked && !soft_clr) |=> $stable(pre_sh));

    // R4
    feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        feed_ev |=> (cnt == $past(rld_act) && !wdg_rst));
endmodule

// File: tb/wdg_top_test.sv
`timescale 1ns/1ps
module wdg_top_test;
    localparam int RW = 6;
    localparam int SYNC = 3;
    localparam int PULSE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        wdg_rst;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdg_top #(.RLD_W(RW), .SYNC_CYCLES(SYNC), .PULSE_CYCLES(PULSE)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdg_rst(wdg_rst)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic wait_rst(input int t0, output int n);
        int lim = 0;
        while (!wdg_rst && lim < 5000) begin @(negedge clk); lim++; end
        n = cyc - t0;
    endtask

    task automatic pulse_len(output int w);
        w = 0;
        while (wdg_rst && w < 100) begin @(negedge clk); w++; end
    endtask

    function automatic int divof(input int c);
        return 4 << ((c > 6) ? 6 : c);
    endfunction

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog timeout of the bench");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v, n, w, t0;
        int rl[3] = '{0, 1, 5};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 rst", int'(wdg_rst), 0);
        rd(2'd1, v); chk("R1 prescaler", v, 0);
        rd(2'd2, v); chk("R1 reload", v, (1 << RW) - 1);
        rd(2'd3, v); chk("R1 status", v, 0);
        rd(2'd0, v); chk("R1 key read", v, 0);

        // R5 locking
        wr(2'd1, 16'd5); rd(2'd1, v); chk("R5 locked prescaler", v, 0);
        wr(2'd2, 16'd7); rd(2'd2, v); chk("R5 locked reload", v, (1 << RW) - 1);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd5); rd(2'd1, v); chk("R5 unlocked prescaler", v, 5);
        wr(2'd0, 16'h1234);
        wr(2'd1, 16'd2); rd(2'd1, v); chk("R5 relocked prescaler", v, 5);

        // R6 pending flags
        repeat (SYNC + 2) @(negedge clk);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd0);
        bus_addr = 2'd3; n = 0;
        #1 chk("R6 pvu set", int'(bus_rdata), 1);
        while (bus_rdata[0] && n < 50) begin @(negedge clk); n++; #1; end
        chk("R6 pvu clear delay", n, SYNC);
        wr(2'd2, 16'd2);
        bus_addr = 2'd3; n = 0;
        #1 chk("R6 rvu set", int'(bus_rdata), 2);
        while (bus_rdata[1] && n < 50) begin @(negedge clk); n++; #1; end
        chk("R6 rvu clear delay", n, SYNC);

        // R9 feed while stopped does not start (code 0, reload 2)
        wr(2'd0, 16'hAAAA);
        wr(2'd0, 16'h0F0F);
        repeat (60) @(negedge clk);
        chk("R9 stays stopped", int'(wdg_rst), 0);

        // R4 feed mid-period
        wr(2'd0, 16'hCCCC);
        repeat (7) @(negedge clk);
        wr(2'd0, 16'hAAAA); t0 = cyc;
        wait_rst(t0, n); chk("R4 timeout after feed", n, 12);
        pulse_len(w); chk("R8 pulse width", w, PULSE);

        // R8 power-on state afterwards
        rd(2'd2, v); chk("R8 reload restored", v, (1 << RW) - 1);
        rd(2'd3, v); chk("R8 status cleared", v, 0);
        wr(2'd1, 16'd3); rd(2'd1, v); chk("R8 locked again", v, 0);

        // R7 cannot stop or restart
        wr(2'd0, 16'h5555); wr(2'd2, 16'd2);
        repeat (SYNC + 1) @(negedge clk);
        wr(2'd0, 16'hCCCC); t0 = cyc;
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'hCCCC);
        wr(2'd0, 16'h5555);
        wait_rst(t0, n); chk("R7 timeout unchanged", n, 12);
        pulse_len(w);

        // R2 R3 sweep of all codes and several reloads
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 3; k++) begin
                wr(2'd0, 16'h5555);
                wr(2'd1, 16'(c));
                wr(2'd2, 16'(rl[k]));
                repeat (SYNC + 1) @(negedge clk);
                wr(2'd0, 16'hCCCC); t0 = cyc;
                wait_rst(t0, n);
                chk($sformatf("R2 R3 code %0d reload %0d", c, rl[k]), n, (rl[k] + 1) * divof(c));
                pulse_len(w);
                chk("R8 sweep pulse", w, PULSE);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule